// File: doc/BRIEF.md
# Range-Checked Memory Protection Unit with Lookup Probe

This block guards a 32-bit address space with a set of regions, each bounded by an inclusive start block and end block at 32-byte granularity. Software programs regions indirectly. It first writes a region number to the index register. It then writes the start, end or attribute register, and that write lands in the selected region. Every access offered on the check port is compared with all valid regions in parallel. Exactly one hit means the region's attribute bits decide. No hit means the default attribute bits in the enable register decide. Two or more hits are an illegal overlap: the access is refused and flagged, and no region is given priority over another.

A probe lets software ask which region covers an address. Software writes the address to the probe register. A two-state machine then writes the lookup result into the index register. The states are `PB_IDLE` (waiting) and `PB_LOOK` (one lookup cycle). The transitions are:
- *start*: `PB_IDLE` to `PB_LOOK` on a probe write.
- *complete*: `PB_LOOK` to `PB_IDLE` when the result is stored.
- *restart*: `PB_LOOK` to `PB_LOOK` on another probe write.
- *abort*: `PB_LOOK` to `PB_IDLE` on an index write, which discards the result.

Top module: `prot_unit`

## Requirements
- R1: After reset every region is invalid, the index register and the default attributes read 0, and any access is refused with no overlap flag.
- R2: Registers are selected by `cfg_sel`: 0 enable, 1 build, 2 index, 3 start, 4 end, 5 attribute, 6 probe. Start and end act on the indexed region: a write keeps bits [31:5], and a read returns them with bits [4:0] at zero. An attribute write keeps bits [11:0] and bit 16, and a read returns only those bits.
- R3: The build register is read-only and returns the region count in bits [15:8].
- R4: A probe write at clock edge k causes the index register, from edge k+1 on, to return the number of the single region whose start ≤ addr[31:5] ≤ end, with bits [31:30] clear.
- R5: A probe that hits no region returns 0x40000000 (bit 30). A probe that hits two or more regions returns 0x80000000 (bit 31).
- R6: An index write sets the index to wdata[7:0] and clears both flags. If it comes in the cycle after a probe write, that probe's result is discarded.
- R7: Matching is inclusive at 32-byte granularity: every byte of the end block hits, and the byte after it misses.
- R8: With one hit, the access is allowed only if the region's attribute bit for the access is set. The attribute bits are: bit 1 kernel read, bit 2 kernel write, bit 3 kernel execute, bit 4 user read, bit 5 user write, bit 6 user execute. `acc_kind` selects the access type: 0 read, 1 write, 2 execute; 3 is always refused.
- R9: With no hit, enable bits [11:0] act as the attribute bits; the enable register reads back only those bits.
- R10: An access hitting two or more valid regions raises `chk_multi` and is refused, whatever the attributes.
- R11: A region whose attribute bit 0 (valid) is clear takes part in neither checking nor probing.
- R12: While the index is at or above the region count, start, end and attribute writes have no effect and those registers read 0.
- R13: Every access on the check port produces exactly one result, with `chk_done` high in the cycle after `acc_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational from cfg_sel) |
| acc_valid | input | 1 | Access to check |
| acc_addr | input | 32 | Access byte address |
| acc_kind | input | 2 | 0 read, 1 write, 2 execute |
| acc_user | input | 1 | 1 user mode, 0 kernel mode |
| chk_done | output | 1 | Result valid |
| chk_allow | output | 1 | Access permitted |
| chk_multi | output | 1 | Overlapping regions hit |
| chk_hit | output | 1 | Exactly one region hit |
| chk_region | output | 3 | Hit region number |

## Verification
Check results are registered and appear one edge after `acc_valid`. The bench's driver pushes the expected verdict for each access into a queue. A monitor samples on falling edges and pops an entry only when `chk_done` is high, so a late, early or extra result shows up as a mismatch or as a result with nothing to pop. A probe result is due two edges after the probe write is driven: one edge to take the address and one to store the result. The bench therefore reads the index register on the falling edge that follows that second edge. Register reads are combinational and are sampled shortly after `cfg_sel` settles.

// File: rtl/prot_pkg.sv
package prot_pkg;
    localparam int DATA_W   = 32;
    localparam int GRAN_W   = 5;
    localparam int BLK_W    = DATA_W - GRAN_W;
    localparam int ATTR_W   = 12;
    localparam int IDXF_W   = 8;

    localparam logic [2:0] RS_ENABLE = 3'd0;
    localparam logic [2:0] RS_BUILD  = 3'd1;
    localparam logic [2:0] RS_INDEX  = 3'd2;
    localparam logic [2:0] RS_START  = 3'd3;
    localparam logic [2:0] RS_END    = 3'd4;
    localparam logic [2:0] RS_ATTR   = 3'd5;
    localparam logic [2:0] RS_PROBE  = 3'd6;

    localparam int AB_VALID = 0;
    localparam int AB_KBASE = 1;
    localparam int AB_UBASE = 4;
    localparam int SID_BIT  = 16;

    typedef enum logic [1:0] {
        AK_READ  = 2'd0,
        AK_WRITE = 2'd1,
        AK_EXEC  = 2'd2,
        AK_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic {
        PB_IDLE = 1'b0,
        PB_LOOK = 1'b1
    } probe_st_e;
endpackage

// File: rtl/prot_region_file.sv
module prot_region_file #(
    parameter int NREG   = 8,
    parameter int BLK_W  = 27,
    parameter int ATTR_W = 12
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_start,
    input  logic                             wr_end,
    input  logic                             wr_attr,
    input  logic [7:0]                       sel,
    input  logic [31:0]                      wdata,
    output logic [NREG-1:0][BLK_W-1:0]       start_q,
    output logic [NREG-1:0][BLK_W-1:0]       end_q,
    output logic [NREG-1:0][ATTR_W-1:0]      attr_q,
    output logic [NREG-1:0]                  sid_q
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic hit_sel;
        assign hit_sel = (sel == 8'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                start_q[g] <= '0;
                end_q[g]   <= '0;
                attr_q[g]  <= '0;
                sid_q[g]   <= 1'b0;
            end else if (hit_sel) begin
                if (wr_start) start_q[g] <= wdata[31 -: BLK_W];
                if (wr_end)   end_q[g]   <= wdata[31 -: BLK_W];
                if (wr_attr) begin
                    attr_q[g] <= wdata[ATTR_W-1:0];
                    sid_q[g]  <= wdata[prot_pkg::SID_BIT];
                end
            end
        end
    end
endmodule

// File: rtl/prot_range_match.sv
module prot_range_match #(
    parameter int NREG  = 8,
    parameter int BLK_W = 27,
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic [BLK_W-1:0]            blk,
    input  logic [NREG-1:0][BLK_W-1:0]  start_q,
    input  logic [NREG-1:0][BLK_W-1:0]  end_q,
    input  logic [NREG-1:0]             valid,
    output logic                        none,
    output logic                        multi,
    output logic [IDX_W-1:0]            idx
);
    logic [NREG-1:0] hit;

    for (genvar g = 0; g < NREG; g++) begin : g_cmp
        assign hit[g] = valid[g] && (start_q[g] <= blk) && (blk <= end_q[g]);
    end

    always_comb begin
        logic found;
        found = 1'b0;
        multi = 1'b0;
        idx   = '0;
        for (int i = 0; i < NREG; i++) begin
            if (hit[i]) begin
                if (found) multi = 1'b1;
                else idx = IDX_W'(i);
                found = 1'b1;
            end
        end
        none = !found;
    end

    always_comb begin
        assert (!(none && multi)) else $error("p_none_vs_multi_r5");
    end
endmodule

// File: rtl/prot_probe_fsm.sv
module prot_probe_fsm #(
    parameter int NREG  = 8,
    parameter int BLK_W = 27,
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              probe_wr,
    input  logic              idx_wr,
    input  logic [31:0]       wdata,
    input  logic              m_none,
    input  logic              m_multi,
    input  logic [IDX_W-1:0]  m_idx,
    output logic [BLK_W-1:0]  look_blk,
    output logic [7:0]        index_q,
    output logic              nomatch_q,
    output logic              multi_q
);
    import prot_pkg::*;

    probe_st_e st, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= PB_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            PB_IDLE: if (probe_wr) st_nx = PB_LOOK;
            PB_LOOK: begin
                if (idx_wr)        st_nx = PB_IDLE;
                else if (probe_wr) st_nx = PB_LOOK;
                else               st_nx = PB_IDLE;
            end
            default: st_nx = PB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            look_blk  <= '0;
            index_q   <= '0;
            nomatch_q <= 1'b0;
            multi_q   <= 1'b0;
        end else begin
            if (probe_wr) look_blk <= wdata[31 -: BLK_W];
            if (idx_wr) begin
                index_q   <= wdata[7:0];
                nomatch_q <= 1'b0;
                multi_q   <= 1'b0;
            end else if (st == PB_LOOK && !probe_wr) begin
                nomatch_q <= m_none;
                multi_q   <= m_multi;
                index_q   <= (m_none || m_multi) ? 8'd0 : 8'(m_idx);
            end
        end
    end

    p_probe_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PB_IDLE && probe_wr) |=> (st == PB_LOOK));
    p_look_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PB_LOOK && !probe_wr) |=> (st == PB_IDLE));
    p_flags_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({nomatch_q, multi_q}));
    p_idx_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> (!nomatch_q && !multi_q && index_q == $past(wdata[7:0])));
endmodule

// File: rtl/prot_unit.sv
module prot_unit #(
    parameter int NREG = 8,
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              acc_valid,
    input  logic [31:0]       acc_addr,
    input  logic [1:0]        acc_kind,
    input  logic              acc_user,
    output logic              chk_done,
    output logic              chk_allow,
    output logic              chk_multi,
    output logic              chk_hit,
    output logic [IDX_W-1:0]  chk_region
);
    import prot_pkg::*;

    logic [NREG-1:0][BLK_W-1:0]  start_q, end_q;
    logic [NREG-1:0][ATTR_W-1:0] attr_q;
    logic [NREG-1:0]             sid_q, valid;
    logic [ATTR_W-1:0]           dflt_q;
    logic [7:0]                  index_q;
    logic                        nomatch_q, multi_q;
    logic [BLK_W-1:0]            look_blk;
    logic                        p_none, p_multi, a_none, a_multi;
    logic [IDX_W-1:0]            p_idx, a_idx;
    logic                        sel_ok;
    logic [IDX_W-1:0]            sel_i;

    logic wr_en, wr_idx, wr_start, wr_end, wr_attr, wr_probe;
    assign wr_en    = cfg_we && (cfg_sel == RS_ENABLE);
    assign wr_idx   = cfg_we && (cfg_sel == RS_INDEX);
    assign wr_start = cfg_we && (cfg_sel == RS_START);
    assign wr_end   = cfg_we && (cfg_sel == RS_END);
    assign wr_attr  = cfg_we && (cfg_sel == RS_ATTR);
    assign wr_probe = cfg_we && (cfg_sel == RS_PROBE);

    for (genvar g = 0; g < NREG; g++) begin : g_valid
        assign valid[g] = attr_q[g][AB_VALID];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     dflt_q <= '0;
        else if (wr_en) dflt_q <= cfg_wdata[ATTR_W-1:0];
    end

    prot_region_file #(.NREG(NREG), .BLK_W(BLK_W), .ATTR_W(ATTR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_start(wr_start), .wr_end(wr_end), .wr_attr(wr_attr),
        .sel(index_q), .wdata(cfg_wdata),
        .start_q(start_q), .end_q(end_q), .attr_q(attr_q), .sid_q(sid_q)
    );

    prot_range_match #(.NREG(NREG), .BLK_W(BLK_W)) u_probe_match (
        .blk(look_blk), .start_q(start_q), .end_q(end_q), .valid(valid),
        .none(p_none), .multi(p_multi), .idx(p_idx)
    );

    prot_range_match #(.NREG(NREG), .BLK_W(BLK_W)) u_acc_match (
        .blk(acc_addr[31 -: BLK_W]), .start_q(start_q), .end_q(end_q),
        .valid(valid), .none(a_none), .multi(a_multi), .idx(a_idx)
    );

    prot_probe_fsm #(.NREG(NREG), .BLK_W(BLK_W)) u_probe (
        .clk(clk), .rst_n(rst_n), .probe_wr(wr_probe), .idx_wr(wr_idx),
        .wdata(cfg_wdata), .m_none(p_none), .m_multi(p_multi), .m_idx(p_idx),
        .look_blk(look_blk), .index_q(index_q), .nomatch_q(nomatch_q),
        .multi_q(multi_q)
    );

    assign sel_ok = ({24'd0, index_q} < NREG);
    assign sel_i  = index_q[IDX_W-1:0];

    always_comb begin
        cfg_rdata = '0;
        case (cfg_sel)
            RS_ENABLE: cfg_rdata = {{(DATA_W-ATTR_W){1'b0}}, dflt_q};
            RS_BUILD:  cfg_rdata = {16'd0, 8'(NREG), 8'd0};
            RS_INDEX:  cfg_rdata = {multi_q, nomatch_q, 22'd0, index_q};
            RS_START:  if (sel_ok) cfg_rdata = {start_q[sel_i], {GRAN_W{1'b0}}};
            RS_END:    if (sel_ok) cfg_rdata = {end_q[sel_i], {GRAN_W{1'b0}}};
            RS_ATTR:   if (sel_ok) cfg_rdata = {15'd0, sid_q[sel_i], 4'd0, attr_q[sel_i]};
            default:   cfg_rdata = '0;
        endcase
    end

    logic [ATTR_W-1:0] eff_attr;
    logic              need_ok;
    always_comb begin
        eff_attr = a_none ? dflt_q : attr_q[a_idx];
        if (acc_kind == AK_RSVD) need_ok = 1'b0;
        else need_ok = eff_attr[(acc_user ? AB_UBASE : AB_KBASE) + int'(acc_kind)];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_done   <= 1'b0;
            chk_allow  <= 1'b0;
            chk_multi  <= 1'b0;
            chk_hit    <= 1'b0;
            chk_region <= '0;
        end else begin
            chk_done <= acc_valid;
            if (acc_valid) begin
                chk_multi  <= a_multi;
                chk_hit    <= !a_none && !a_multi;
                chk_region <= a_idx;
                chk_allow  <= !a_multi && need_ok;
            end
        end
    end

    p_chk_latency_r13: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> chk_done);
    p_chk_no_spurious_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !chk_done);
    p_multi_denies_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_done && chk_multi) |-> (!chk_allow && !chk_hit));
endmodule

// File: tb/test_prot_unit.sv
`timescale 1ns/1ps
module test_prot_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = 3'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_kind = '0;
    logic        acc_user = 1'b0;
    logic        chk_done, chk_allow, chk_multi, chk_hit;
    logic [2:0]  chk_region;

    int n_run = 0;
    int n_fail = 0;
    bit done_all = 0;

    typedef struct packed { logic allow; logic multi; } exp_t;
    exp_t       exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    prot_unit #(.NREG(8)) i_prot_unit (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_kind(acc_kind), .acc_user(acc_user),
        .chk_done(chk_done), .chk_allow(chk_allow), .chk_multi(chk_multi),
        .chk_hit(chk_hit), .chk_region(chk_region)
    );

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [2:0] sel, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(string tag, logic [2:0] sel, logic [31:0] exp);
        cfg_sel = sel;
        #1;
        check(tag, cfg_rdata, exp);
    endtask

    task automatic region(int idx, logic [31:0] s, logic [31:0] e, logic [31:0] a);
        wr(3'd2, idx);
        wr(3'd3, s);
        wr(3'd4, e);
        wr(3'd5, a);
    endtask

    task automatic probe(string tag, logic [31:0] addr, logic [31:0] exp);
        wr(3'd6, addr);
        @(negedge clk);
        rd(tag, 3'd2, exp);
    endtask

    task automatic acc(string tag, logic [31:0] a, logic [1:0] k, logic u,
                       logic ex_allow, logic ex_multi);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_kind = k; acc_user = u;
        exp_q.push_back('{allow: ex_allow, multi: ex_multi});
        tag_q.push_back(tag);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    // monitor: pops one expected verdict per result
    always @(negedge clk) begin
        if (rst_n && chk_done) begin
            if (exp_q.size() == 0) begin
                check("R13 unexpected result", 32'(chk_done), 32'd0);
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({t, " allow"}, 32'(chk_allow), 32'(e.allow));
                check({t, " multi"}, 32'(chk_multi), 32'(e.multi));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_all) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd("R1 index reset", 3'd2, 32'h0);
        rd("R1 enable reset", 3'd0, 32'h0);
        acc("R1 reset access denied", 32'h1000, 2'd0, 1'b0, 1'b0, 1'b0);
        // R3 build register
        rd("R3 build count", 3'd1, 32'h0000_0800);
        wr(3'd1, 32'hFFFF_FFFF);
        rd("R3 build read-only", 3'd1, 32'h0000_0800);

        // program regions
        region(0, 32'h1000, 32'h10E0, 32'h17);
        region(1, 32'h2000, 32'h2000, 32'h7F);
        region(2, 32'h3000, 32'h3FE0, 32'h7E);
        // R2 readback and masking
        wr(3'd2, 0);
        rd("R2 start readback", 3'd3, 32'h1000);
        rd("R2 end readback", 3'd4, 32'h10E0);
        wr(3'd2, 3);
        wr(3'd3, 32'h101F);
        rd("R2 start low bits zero", 3'd3, 32'h1000);
        wr(3'd2, 4);
        wr(3'd5, 32'hFFFF_FFFF);
        rd("R2 attr mask", 3'd5, 32'h0001_0FFF);
        wr(3'd5, 32'h0);
        // R12 out-of-range index
        wr(3'd2, 12);
        wr(3'd3, 32'h5000);
        rd("R12 start reads zero", 3'd3, 32'h0);
        rd("R12 index holds value", 3'd2, 32'd12);
        wr(3'd2, 0);
        rd("R12 region0 untouched", 3'd3, 32'h1000);

        // R4 R7 probes
        probe("R4 probe hit region1", 32'h201F, 32'd1);
        probe("R7 probe last byte of end block", 32'h10FF, 32'd0);
        probe("R5 R7 probe past end", 32'h1100, 32'h4000_0000);
        probe("R7 probe before start", 32'h0FFF, 32'h4000_0000);
        probe("R11 probe invalid region", 32'h3000, 32'h4000_0000);

        // R8 attribute checks
        acc("R8 user read", 32'h1040, 2'd0, 1'b1, 1'b1, 1'b0);
        acc("R8 user write", 32'h1040, 2'd1, 1'b1, 1'b0, 1'b0);
        acc("R8 kernel write", 32'h1040, 2'd1, 1'b0, 1'b1, 1'b0);
        acc("R8 kernel exec", 32'h1040, 2'd2, 1'b0, 1'b0, 1'b0);
        acc("R8 reserved kind", 32'h2000, 2'd3, 1'b0, 1'b0, 1'b0);
        acc("R7 end block inclusive", 32'h10FF, 2'd0, 1'b0, 1'b1, 1'b0);
        acc("R7 R9 past end default", 32'h1100, 2'd0, 1'b0, 1'b0, 1'b0);
        acc("R11 invalid region ignored", 32'h3000, 2'd0, 1'b0, 1'b0, 1'b0);

        // R9 default attributes
        wr(3'd0, 32'hFFFF_FFFF);
        rd("R9 enable mask", 3'd0, 32'h0000_0FFF);
        wr(3'd0, 32'h2);
        acc("R9 default kernel read", 32'h5000, 2'd0, 1'b0, 1'b1, 1'b0);
        acc("R9 default user read", 32'h5000, 2'd0, 1'b1, 1'b0, 1'b0);

        // R6 index write aborts a probe in flight
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'd6; cfg_wdata = 32'h201F;
        @(negedge clk);
        cfg_sel = 3'd2; cfg_wdata = 32'd5;
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
        rd("R6 index write wins", 3'd2, 32'd5);

        // R5 R10 overlap
        region(3, 32'h2000, 32'h2000, 32'h03);
        probe("R5 probe multiple hit", 32'h2000, 32'h8000_0000);
        wr(3'd2, 2);
        rd("R6 index write clears flags", 3'd2, 32'd2);
        acc("R10 overlap denied", 32'h2010, 2'd0, 1'b0, 1'b0, 1'b1);

        repeat (3) @(negedge clk);
        check("R13 all results seen", 32'(exp_q.size()), 32'd0);
        done_all = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule